// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Queue

This block turns an asynchronous serial input into bytes. A shared divider supplies a tick at thirteen times the bit rate. The receiver uses that tick to find start bits and to sample each bit near its centre. It builds 7- or 8-bit characters, checks parity when parity is enabled, and checks the first stop bit. Each finished character goes into a 16-deep queue. Each queue entry is 10 bits wide: the data plus two error tags that belong to that character alone.

Downstream logic reads the head of the queue and pops it. It watches the occupancy count and a set of event outputs:

- data present
- almost full
- full
- overrun
- parity error
- framing error
- idle timeout

The idle timeout fires once when characters are waiting and the line has shown no new start bit for a programmed number of character times.

The line input is taken to be already synchronous to `clk`.

Top module: `serial_rx_tagged`

## Requirements
- R1: After reset the queue is empty: `count_o` is 0, and `ev_data_o`, `ev_afull_o`, `ev_full_o` and all pulse events are low.
- R2: A character is a low start bit, then the data bits LSB first, then an optional parity bit, then a stop bit. A character received with `char8_i`=1 is stored as a 10-bit entry with the data in bits 7:0, and `count_o` rises by one.
- R3: With `char8_i`=0, seven data bits are received and bit 7 of the stored entry is 0.
- R4: With `par_en_i`=1, bit 8 of the entry is 1 exactly when the received parity bit does not match. Even parity applies when `par_odd_i`=0 and odd parity when it is 1. `ev_perr_o` pulses for such a character.
- R5: Bit 9 of the entry is 1 when the stop bit samples low, and `ev_ferr_o` pulses.
- R6: A start is accepted only if the line is still low on the sixth tick after the falling edge was seen. A shorter low pulse stores nothing.
- R7: The queue returns entries in arrival order. `count_o` runs from 0 to 16. `ev_afull_o` is high when the count is 12 or more, and `ev_full_o` is high when the count is 16.
- R8: A character that completes while the queue is full and no pop is requested is discarded. `ev_overrun_o` pulses for one cycle and the stored entries are unchanged.
- R9: If a character completes while the queue is full, in the same cycle as a pop, it is stored: there is no overrun and the count stays 16.
- R10: While `rx_en_i` is 0, no character is received.
- R11: When `to_chars_i` is nonzero, `ev_timeout_o` pulses once after the queue has been non-empty with no start bit for `to_chars_i` character times. One character time is 130 ticks. The event never fires while the queue is empty.
- R12: A pop on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oversampling tick, 13 per bit |
| rxd_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| char8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| to_chars_i | input | 8 | Idle timeout in character times, 0 disables it |
| pop_i | input | 1 | Remove the head entry |
| rd_data_o | output | 10 | Head entry: {framing err, parity err, data[7:0]} |
| count_o | output | 5 | Queue occupancy, 0 to 16 |
| ev_data_o | output | 1 | Queue non-empty |
| ev_afull_o | output | 1 | Occupancy of 12 or more |
| ev_full_o | output | 1 | Occupancy of 16 |
| ev_overrun_o | output | 1 | Pulse: a character was discarded |
| ev_perr_o | output | 1 | Pulse: a character completed with a parity error |
| ev_ferr_o | output | 1 | Pulse: a character completed with a framing error |
| ev_timeout_o | output | 1 | Pulse: the idle timeout expired |

## Verification
Two functions can fall in the same cycle: a character completes and is written into a full queue, and downstream logic pops the head.

The bench provokes this by raising `pop_i` for exactly the cycle in which the stop-bit result is written. It works that cycle out from the tick count of the frame it is driving.

The outcome is judged at the ports. The overrun pulse count must not change, the occupancy must stay at 16, and draining the queue must show the new character last and the old head gone.

A second, neighbouring case is also run: the same arrival with no pop must be discarded, and the head must be untouched.

// File: rtl/rxt_pkg.sv
package rxt_pkg;

    localparam int OVS_DEF       = 13;
    localparam int START_TAP_DEF = 6;
    localparam int CHAR_BITTIMES = 10;

    typedef struct packed {
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

    function automatic logic parity_bad(input logic [7:0] d,
                                        input logic       pbit,
                                        input logic       odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/rxt_deser.sv
module rxt_deser
    import rxt_pkg::*;
#(
    parameter int OVS       = OVS_DEF,
    parameter int START_TAP = START_TAP_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      en,
    input  logic      char8,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      busy,
    output logic      out_valid,
    output rx_entry_t out_entry
);
    localparam int CNTW = $clog2(OVS);

    rx_state_e       state;
    logic [CNTW-1:0] cnt;
    logic [2:0]      bitn;
    logic [7:0]      shreg;
    logic            pbit;
    logic            mid;
    logic [7:0]      dval;

    // mid is the centre sample of a data, parity or stop bit
    assign mid  = (cnt == CNTW'(OVS - 1));
    assign dval = char8 ? shreg : {1'b0, shreg[7:1]};
    assign busy = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            pbit      <= 1'b0;
            out_valid <= 1'b0;
            out_entry <= '0;
        end else begin
            out_valid <= 1'b0;
            if (!en) begin
                state <= S_IDLE;
            end else if (tick) begin
                unique case (state)
                    S_IDLE: begin
                        if (!rxd) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == CNTW'(START_TAP - 1)) begin
                            cnt   <= '0;
                            bitn  <= '0;
                            state <= rxd ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (mid) begin
                            cnt   <= '0;
                            shreg <= {rxd, shreg[7:1]};
                            bitn  <= bitn + 1'b1;
                            if (bitn == (char8 ? 3'd7 : 3'd6))
                                state <= par_en ? S_PAR : S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (mid) begin
                            cnt   <= '0;
                            pbit  <= rxd;
                            state <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (mid) begin
                            cnt            <= '0;
                            out_valid      <= 1'b1;
                            out_entry.data <= dval;
                            out_entry.perr <= par_en && parity_bad(dval, pbit, par_odd);
                            out_entry.ferr <= !rxd;
                            state          <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rxt_fifo.sv
module rxt_fifo
    import rxt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  rx_entry_t                  push_entry,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    output logic                       ovr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;
    logic            push_ok;
    logic            pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign pop_ok  = pop && !empty;
    // a pop in the same cycle frees the slot the arrival needs
    assign push_ok = push && (!full || pop);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            ovr <= push && !push_ok;
            if (push_ok) begin
                mem[wptr] <= push_entry;
                wptr      <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (pop_ok)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/rxt_idle_timer.sv
module rxt_idle_timer
    import rxt_pkg::*;
#(
    parameter int OVS  = OVS_DEF,
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            busy,
    input  logic            nonempty,
    input  logic [TO_W-1:0] thr,
    output logic            fire
);
    localparam int LIM = OVS * CHAR_BITTIMES;
    localparam int TW  = $clog2(LIM);

    logic [TW-1:0]   tcnt;
    logic [TO_W-1:0] chars;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt  <= '0;
            chars <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (busy || !nonempty || thr == '0) begin
                tcnt  <= '0;
                chars <= '0;
            end else if (tick && chars < thr) begin
                if (tcnt == TW'(LIM - 1)) begin
                    tcnt  <= '0;
                    chars <= chars + 1'b1;
                    if (chars == thr - 1'b1)
                        fire <= 1'b1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
    import rxt_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int AFULL     = 12,
    parameter int OVS       = OVS_DEF,
    parameter int START_TAP = START_TAP_DEF,
    parameter int TO_W      = 8,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_i,
    input  logic            rxd_i,
    input  logic            rx_en_i,
    input  logic            char8_i,
    input  logic            par_en_i,
    input  logic            par_odd_i,
    input  logic [TO_W-1:0] to_chars_i,
    input  logic            pop_i,
    output logic [9:0]      rd_data_o,
    output logic [CW-1:0]   count_o,
    output logic            ev_data_o,
    output logic            ev_afull_o,
    output logic            ev_full_o,
    output logic            ev_overrun_o,
    output logic            ev_perr_o,
    output logic            ev_ferr_o,
    output logic            ev_timeout_o
);
    logic      rx_busy;
    logic      rx_valid;
    rx_entry_t rx_entry;
    rx_entry_t head;
    logic      q_full;
    logic      q_empty;

    rxt_deser #(.OVS(OVS), .START_TAP(START_TAP)) u_deser (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_i),
        .rxd       (rxd_i),
        .en        (rx_en_i),
        .char8     (char8_i),
        .par_en    (par_en_i),
        .par_odd   (par_odd_i),
        .busy      (rx_busy),
        .out_valid (rx_valid),
        .out_entry (rx_entry)
    );

    rxt_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (rx_valid),
        .push_entry (rx_entry),
        .pop        (pop_i),
        .head       (head),
        .count      (count_o),
        .full       (q_full),
        .empty      (q_empty),
        .ovr        (ev_overrun_o)
    );

    rxt_idle_timer #(.OVS(OVS), .TO_W(TO_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_i),
        .busy     (rx_busy),
        .nonempty (!q_empty),
        .thr      (to_chars_i),
        .fire     (ev_timeout_o)
    );

    assign rd_data_o  = head;
    assign ev_data_o  = !q_empty;
    assign ev_full_o  = q_full;
    assign ev_afull_o = (count_o >= CW'(AFULL));
    assign ev_perr_o  = rx_valid && rx_entry.perr;
    assign ev_ferr_o  = rx_valid && rx_entry.ferr;

endmodule

// File: rtl/serial_rx_tagged_chk.sv
module serial_rx_tagged_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          pop_i,
    input logic          push_v,
    input logic [CW-1:0] count_o,
    input logic          ev_data_o,
    input logic          ev_afull_o,
    input logic          ev_full_o,
    input logic          ev_overrun_o,
    input logic          ev_timeout_o
);
    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_o <= CW'(DEPTH));

    // R7
    full_implies_afull_chk: assert property (@(posedge clk) disable iff (rst)
        ev_full_o |-> ev_afull_o);

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, count_o} <= {1'b0, $past(count_o)} + 1'b1) &&
        ({1'b0, count_o} + 1'b1 >= {1'b0, $past(count_o)}));

    // R8
    overrun_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        ev_overrun_o |-> (ev_full_o && $stable(count_o)));

    // R9
    full_pop_push_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_full_o && pop_i && push_v) |=> (ev_full_o && !ev_overrun_o));

    // R12
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (count_o == '0 && pop_i && !push_v) |=> (count_o == '0));

    // R11
    timeout_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        ev_timeout_o |-> $past(ev_data_o));

endmodule

bind serial_rx_tagged serial_rx_tagged_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pop_i        (pop_i),
    .push_v       (rx_valid),
    .count_o      (count_o),
    .ev_data_o    (ev_data_o),
    .ev_afull_o   (ev_afull_o),
    .ev_full_o    (ev_full_o),
    .ev_overrun_o (ev_overrun_o),
    .ev_timeout_o (ev_timeout_o)
);

// File: tb/serial_rx_tagged_test.sv
`timescale 1ns/1ps
module serial_rx_tagged_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b1;
    logic       rxd_i = 1'b1;
    logic       rx_en_i = 1'b1;
    logic       char8_i = 1'b1;
    logic       par_en_i = 1'b0;
    logic       par_odd_i = 1'b0;
    logic [7:0] to_chars_i = 8'd0;
    logic       pop_i = 1'b0;
    logic [9:0] rd_data_o;
    logic [4:0] count_o;
    logic       ev_data_o, ev_afull_o, ev_full_o;
    logic       ev_overrun_o, ev_perr_o, ev_ferr_o, ev_timeout_o;

    int n_checks = 0;
    int n_fail   = 0;
    int ovr_cnt  = 0;
    int perr_cnt = 0;
    int ferr_cnt = 0;
    int to_cnt   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    serial_rx_tagged uut (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .rxd_i        (rxd_i),
        .rx_en_i      (rx_en_i),
        .char8_i      (char8_i),
        .par_en_i     (par_en_i),
        .par_odd_i    (par_odd_i),
        .to_chars_i   (to_chars_i),
        .pop_i        (pop_i),
        .rd_data_o    (rd_data_o),
        .count_o      (count_o),
        .ev_data_o    (ev_data_o),
        .ev_afull_o   (ev_afull_o),
        .ev_full_o    (ev_full_o),
        .ev_overrun_o (ev_overrun_o),
        .ev_perr_o    (ev_perr_o),
        .ev_ferr_o    (ev_ferr_o),
        .ev_timeout_o (ev_timeout_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ev_overrun_o) ovr_cnt++;
            if (ev_perr_o)    perr_cnt++;
            if (ev_ferr_o)    ferr_cnt++;
            if (ev_timeout_o) to_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One frame, bit cells of 13 clocks; tick is high every clock.
    task automatic send_frame(input logic [7:0] d, input logic bad_par,
                              input logic stop_v, input logic pop_at_stop);
        logic [7:0] de;
        int nd;
        logic pb;
        de = char8_i ? d : {1'b0, d[6:0]};
        nd = char8_i ? 8 : 7;
        pb = (^de) ^ par_odd_i ^ bad_par;
        @(negedge clk);
        rxd_i = 1'b0;
        repeat (13) @(negedge clk);
        for (int i = 0; i < nd; i++) begin
            rxd_i = de[i];
            repeat (13) @(negedge clk);
        end
        if (par_en_i) begin
            rxd_i = pb;
            repeat (13) @(negedge clk);
        end
        rxd_i = stop_v;
        if (pop_at_stop) begin
            // the stored write lands on the 7th edge of the stop cell
            repeat (7) @(negedge clk);
            pop_i = 1'b1;
            @(negedge clk);
            pop_i = 1'b0;
            repeat (5) @(negedge clk);
        end else begin
            repeat (13) @(negedge clk);
        end
        rxd_i = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pop_one();
        @(negedge clk);
        pop_i = 1'b1;
        @(negedge clk);
        pop_i = 1'b0;
    endtask

    task automatic drain();
        while (count_o != 0) pop_one();
    endtask

    task automatic t_reset();
        chk("R1 count", count_o, 0);
        chk("R1 levels", {ev_data_o, ev_afull_o, ev_full_o}, 0);
        chk("R1 pulses", ovr_cnt + perr_cnt + ferr_cnt + to_cnt, 0);
    endtask

    task automatic t_eight();
        send_frame(8'hA5, 1'b0, 1'b1, 1'b0);
        send_frame(8'h3C, 1'b0, 1'b1, 1'b0);
        chk("R2 count", count_o, 2);
        chk("R2 head", rd_data_o, 10'h0A5);
        pop_one();
        chk("R2 second", rd_data_o, 10'h03C);
        pop_one();
        chk("R2 empty", count_o, 0);
    endtask

    task automatic t_seven();
        char8_i = 1'b0;
        send_frame(8'hD5, 1'b0, 1'b1, 1'b0);
        chk("R3 bit7 zero", rd_data_o, 10'h055);
        pop_one();
        char8_i = 1'b1;
    endtask

    task automatic t_parity();
        int p0;
        par_en_i = 1'b1;
        par_odd_i = 1'b0;
        p0 = perr_cnt;
        send_frame(8'h07, 1'b0, 1'b1, 1'b0);
        chk("R4 even ok", rd_data_o, 10'h007);
        pop_one();
        send_frame(8'h07, 1'b1, 1'b1, 1'b0);
        chk("R4 even bad", rd_data_o, 10'h107);
        pop_one();
        par_odd_i = 1'b1;
        send_frame(8'h81, 1'b0, 1'b1, 1'b0);
        chk("R4 odd ok", rd_data_o, 10'h081);
        pop_one();
        send_frame(8'h81, 1'b1, 1'b1, 1'b0);
        chk("R4 odd bad", rd_data_o, 10'h181);
        pop_one();
        chk("R4 pulses", perr_cnt - p0, 2);
        par_en_i = 1'b0;
        par_odd_i = 1'b0;
    endtask

    task automatic t_frame();
        int f0;
        f0 = ferr_cnt;
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
        chk("R5 tag", rd_data_o, 10'h25A);
        chk("R5 pulse", ferr_cnt - f0, 1);
        pop_one();
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rxd_i = 1'b0;
        repeat (3) @(negedge clk);
        rxd_i = 1'b1;
        repeat (160) @(negedge clk);
        chk("R6 no char", count_o, 0);
    endtask

    task automatic t_disable();
        rx_en_i = 1'b0;
        send_frame(8'h11, 1'b0, 1'b1, 1'b0);
        chk("R10 ignored", count_o, 0);
        rx_en_i = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_empty_pop();
        pop_one();
        pop_one();
        chk("R12 count", count_o, 0);
        send_frame(8'h66, 1'b0, 1'b1, 1'b0);
        chk("R12 intact", rd_data_o, 10'h066);
        pop_one();
    endtask

    task automatic t_fill();
        int o0;
        for (int i = 0; i < 16; i++) begin
            send_frame(8'h10 + 8'(i), 1'b0, 1'b1, 1'b0);
            if (i == 10) chk("R7 afull at 11", ev_afull_o, 0);
            if (i == 11) chk("R7 afull at 12", ev_afull_o, 1);
            if (i == 14) chk("R7 not full at 15", ev_full_o, 0);
        end
        chk("R7 count 16", count_o, 16);
        chk("R7 full", ev_full_o, 1);
        o0 = ovr_cnt;
        send_frame(8'hEE, 1'b0, 1'b1, 1'b0);
        chk("R8 pulse", ovr_cnt - o0, 1);
        chk("R8 count", count_o, 16);
        chk("R8 head kept", rd_data_o, 10'h010);
        send_frame(8'hDD, 1'b0, 1'b1, 1'b1);
        chk("R9 no overrun", ovr_cnt - o0, 1);
        chk("R9 count", count_o, 16);
        for (int i = 1; i < 16; i++) begin
            chk("R7 order", rd_data_o, 10'h010 + i);
            pop_one();
        end
        chk("R9 last entry", rd_data_o, 10'h0DD);
        pop_one();
        chk("R7 drained", count_o, 0);
    endtask

    task automatic t_timeout();
        to_chars_i = 8'd2;
        repeat (600) @(negedge clk);
        chk("R11 empty quiet", to_cnt, 0);
        send_frame(8'h42, 1'b0, 1'b1, 1'b0);
        repeat (200) @(negedge clk);
        chk("R11 not early", to_cnt, 0);
        repeat (200) @(negedge clk);
        chk("R11 fired", to_cnt, 1);
        repeat (400) @(negedge clk);
        chk("R11 once", to_cnt, 1);
        to_chars_i = 8'd0;
        drain();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_eight();
        t_seven();
        t_parity();
        t_frame();
        t_glitch();
        t_disable();
        t_empty_pop();
        t_fill();
        t_timeout();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule